// File: doc/BRIEF.md
# Endpoint Buffer Ownership and Handshake Controller

This block tracks who owns the single 64-byte buffer of one bulk or interrupt endpoint pair, one IN direction and one OUT direction. For each direction it decides which handshake the serial engine returns when a token arrives. The processor side sees four byte-wide registers. Writing a byte count arms a direction and gives the buffer to the serial engine. When a transfer completes, the buffer comes back to the processor and a sticky interrupt flag is raised. A per-direction stall flag makes every token of that direction answer with a stall, whatever the ownership state.

The serial-engine side is event driven. Tokens and host acknowledgements arrive as single-cycle pulses. Each token produces exactly one registered response pulse in the next cycle, carrying a valid strobe and a 2-bit code. The response has no ready signal, because a handshake answer cannot be postponed on the wire. The engine must take the response in the cycle it is valid, and the block never stalls the engine. Processor writes are single-cycle strobes that are always accepted. Reads are combinational on the address.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: After reset, both directions have busy=0, stall=0, interrupt flag=0 and byte count=0, and both interrupt outputs are low.
- R2: Register map: address 0 is IN control and address 2 is OUT control, each laid out as {bit2 interrupt flag, bit1 stall, bit0 busy}. Address 1 is the IN byte count and address 3 is the OUT byte count. Writes to bit0 have no effect on busy.
- R3: A write to the IN byte count while IN busy=0 sets busy=1 on the next cycle and stores the written value, with any value above 64 stored as 64.
- R4: A write to either byte-count register while that direction's busy=1 is ignored: the count and busy are unchanged.
- R5: An IN token with stall=0 gets a response one cycle later. The code is NAK (1) when busy=0. When busy=1 the code is ACK/DATA (0), and in_tx_cnt presents the stored byte count.
- R6: A host acknowledgement that follows an ACK/DATA response, with no other IN token in between, clears IN busy. An acknowledgement without such a preceding response leaves busy at 1.
- R7: While a direction's stall=1, each of its tokens is answered with STALL (2). Busy is unchanged, no interrupt is raised, and this continues until stall is written back to 0.
- R8: A write of any value to the OUT byte count while OUT busy=0 sets busy=1. An OUT token then answers ACK (0), clears busy, and sets the OUT count to the received length, with lengths above 64 stored as 64. An OUT token while busy=0 answers NAK (1).
- R9: A 1-to-0 change of a direction's busy sets its interrupt flag in the same edge, and the flag stays set until a control write with bit2=1. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data, combinational on cpu_addr |
| sie_in_tok | input | 1 | IN token received (pulse) |
| sie_in_ack | input | 1 | Host acknowledged IN data (pulse) |
| sie_out_tok | input | 1 | OUT data packet received (pulse) |
| sie_out_cnt | input | 7 | Received OUT length, valid with sie_out_tok |
| in_resp_vld | output | 1 | IN handshake response valid |
| in_resp_code | output | 2 | IN response: 0 ACK/DATA, 1 NAK, 2 STALL |
| in_tx_cnt | output | 7 | Byte count to transmit for IN |
| out_resp_vld | output | 1 | OUT handshake response valid |
| out_resp_code | output | 2 | OUT response: 0 ACK, 1 NAK, 2 STALL |
| irq_in | output | 1 | IN buffer-returned interrupt flag |
| irq_out | output | 1 | OUT buffer-returned interrupt flag |

## Verification
The assertions check the following on every cycle:
- the stall override and its freezing of busy;
- the NAK answer of an unarmed IN direction;
- the interrupt flag following every busy fall;
- the rule that stored counts never exceed 64;
- the immunity of a busy count register to writes;
- the OUT receive completion.

The bench's scenarios are needed for the rest:
- the clamping sweep over every 7-bit count value in both directions, with expected counts computed arithmetically;
- the ordering rule under which a stray host acknowledgement is ignored;
- the release of stall;
- the write-one-to-clear behaviour of the flags as seen through register reads.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hs_code_e;

  localparam logic [1:0] ADDR_IN_CTL  = 2'd0;
  localparam logic [1:0] ADDR_IN_CNT  = 2'd1;
  localparam logic [1:0] ADDR_OUT_CTL = 2'd2;
  localparam logic [1:0] ADDR_OUT_CNT = 2'd3;

  localparam int unsigned CTL_BUSY_BIT  = 0;
  localparam int unsigned CTL_STALL_BIT = 1;
  localparam int unsigned CTL_IRQ_BIT   = 2;

endpackage

// File: rtl/ep_count_clamp.sv
module ep_count_clamp #(
  parameter int unsigned IN_W      = 8,
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned MAX_BYTES = 64
) (
  input  logic [IN_W-1:0]  raw,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [IN_W-1:0]  MAX_IN  = IN_W'(MAX_BYTES);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);

  generate
    if (IN_W > CNT_W) begin : g_wide
      always_comb cnt = (raw > MAX_IN) ? MAX_CNT : raw[CNT_W-1:0];
    end else begin : g_narrow
      always_comb cnt = (raw > MAX_IN) ? MAX_CNT : CNT_W'(raw);
    end
  endgenerate
endmodule

// File: rtl/ep_irq_flag.sv
module ep_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/ep_in_ctrl.sv
module ep_in_ctrl
  import ep_hs_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] arm_cnt_i,
  input  logic             stall_wr_i,
  input  logic             stall_val_i,
  input  logic             tok_i,
  input  logic             ack_i,
  output logic             busy_o,
  output logic             stall_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             resp_vld_o,
  output hs_code_e         resp_code_o,
  output logic             release_o
);
  logic wait_ack;
  logic arm_ok, data_go, ack_ok;

  always_comb begin
    arm_ok    = arm_i && !busy_o;
    data_go   = tok_i && !stall_o && busy_o;
    ack_ok    = ack_i && wait_ack;
    release_o = ack_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o      <= 1'b0;
      stall_o     <= 1'b0;
      cnt_o       <= '0;
      wait_ack    <= 1'b0;
      resp_vld_o  <= 1'b0;
      resp_code_o <= HS_NAK;
    end else begin
      if (ack_ok)       busy_o <= 1'b0;
      else if (arm_ok)  busy_o <= 1'b1;

      if (arm_ok)       cnt_o <= arm_cnt_i;
      if (stall_wr_i)   stall_o <= stall_val_i;

      if (tok_i)        wait_ack <= data_go && !ack_ok;
      else if (ack_ok)  wait_ack <= 1'b0;

      resp_vld_o <= tok_i;
      if (tok_i) begin
        if (stall_o)      resp_code_o <= HS_STALL;
        else if (busy_o)  resp_code_o <= HS_ACK;
        else              resp_code_o <= HS_NAK;
      end
    end
  end
endmodule

// File: rtl/ep_out_ctrl.sv
module ep_out_ctrl
  import ep_hs_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             stall_wr_i,
  input  logic             stall_val_i,
  input  logic             tok_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  output logic             busy_o,
  output logic             stall_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             resp_vld_o,
  output hs_code_e         resp_code_o,
  output logic             release_o
);
  logic arm_ok, rx_ok;

  always_comb begin
    arm_ok    = arm_i && !busy_o;
    rx_ok     = tok_i && !stall_o && busy_o;
    release_o = rx_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o      <= 1'b0;
      stall_o     <= 1'b0;
      cnt_o       <= '0;
      resp_vld_o  <= 1'b0;
      resp_code_o <= HS_NAK;
    end else begin
      if (rx_ok)        busy_o <= 1'b0;
      else if (arm_ok)  busy_o <= 1'b1;

      if (rx_ok)        cnt_o <= rx_cnt_i;
      if (stall_wr_i)   stall_o <= stall_val_i;

      resp_vld_o <= tok_i;
      if (tok_i) begin
        if (stall_o)      resp_code_o <= HS_STALL;
        else if (busy_o)  resp_code_o <= HS_ACK;
        else              resp_code_o <= HS_NAK;
      end
    end
  end
endmodule

// File: rtl/ep_handshake_ctrl.sv
module ep_handshake_ctrl
  import ep_hs_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 64,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              sie_in_tok,
  input  logic              sie_in_ack,
  input  logic              sie_out_tok,
  input  logic [CNT_W-1:0]  sie_out_cnt,
  output logic              in_resp_vld,
  output logic [1:0]        in_resp_code,
  output logic [CNT_W-1:0]  in_tx_cnt,
  output logic              out_resp_vld,
  output logic [1:0]        out_resp_code,
  output logic              irq_in,
  output logic              irq_out
);
  logic wr_in_ctl, wr_in_cnt, wr_out_ctl, wr_out_cnt;
  logic [CNT_W-1:0] in_arm_cnt, out_rx_cnt;
  logic in_busy, in_stall, in_release;
  logic out_busy, out_stall, out_release;
  logic [CNT_W-1:0] in_cnt, out_cnt;
  hs_code_e in_code, out_code;

  always_comb begin
    wr_in_ctl  = cpu_wr && (cpu_addr == ADDR_IN_CTL);
    wr_in_cnt  = cpu_wr && (cpu_addr == ADDR_IN_CNT);
    wr_out_ctl = cpu_wr && (cpu_addr == ADDR_OUT_CTL);
    wr_out_cnt = cpu_wr && (cpu_addr == ADDR_OUT_CNT);
  end

  ep_count_clamp #(.IN_W(DATA_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) u_in_clamp (
    .raw(cpu_wdata), .cnt(in_arm_cnt)
  );

  ep_count_clamp #(.IN_W(CNT_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) u_out_clamp (
    .raw(sie_out_cnt), .cnt(out_rx_cnt)
  );

  ep_in_ctrl #(.CNT_W(CNT_W)) u_in (
    .clk(clk), .rst_n(rst_n),
    .arm_i(wr_in_cnt), .arm_cnt_i(in_arm_cnt),
    .stall_wr_i(wr_in_ctl), .stall_val_i(cpu_wdata[CTL_STALL_BIT]),
    .tok_i(sie_in_tok), .ack_i(sie_in_ack),
    .busy_o(in_busy), .stall_o(in_stall), .cnt_o(in_cnt),
    .resp_vld_o(in_resp_vld), .resp_code_o(in_code), .release_o(in_release)
  );

  ep_out_ctrl #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .arm_i(wr_out_cnt),
    .stall_wr_i(wr_out_ctl), .stall_val_i(cpu_wdata[CTL_STALL_BIT]),
    .tok_i(sie_out_tok), .rx_cnt_i(out_rx_cnt),
    .busy_o(out_busy), .stall_o(out_stall), .cnt_o(out_cnt),
    .resp_vld_o(out_resp_vld), .resp_code_o(out_code), .release_o(out_release)
  );

  ep_irq_flag u_irq_in (
    .clk(clk), .rst_n(rst_n), .set_i(in_release),
    .clr_i(wr_in_ctl && cpu_wdata[CTL_IRQ_BIT]), .flag_o(irq_in)
  );

  ep_irq_flag u_irq_out (
    .clk(clk), .rst_n(rst_n), .set_i(out_release),
    .clr_i(wr_out_ctl && cpu_wdata[CTL_IRQ_BIT]), .flag_o(irq_out)
  );

  assign in_resp_code  = in_code;
  assign out_resp_code = out_code;
  assign in_tx_cnt     = in_cnt;

  always_comb begin
    cpu_rdata = '0;
    unique case (cpu_addr)
      ADDR_IN_CTL: begin
        cpu_rdata[CTL_BUSY_BIT]  = in_busy;
        cpu_rdata[CTL_STALL_BIT] = in_stall;
        cpu_rdata[CTL_IRQ_BIT]   = irq_in;
      end
      ADDR_IN_CNT:  cpu_rdata[CNT_W-1:0] = in_cnt;
      ADDR_OUT_CTL: begin
        cpu_rdata[CTL_BUSY_BIT]  = out_busy;
        cpu_rdata[CTL_STALL_BIT] = out_stall;
        cpu_rdata[CTL_IRQ_BIT]   = irq_out;
      end
      default:      cpu_rdata[CNT_W-1:0] = out_cnt;
    endcase
  end
endmodule

// File: rtl/ep_hs_checker.sv
module ep_hs_checker #(
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned MAX_BYTES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_wr,
  input logic [1:0]       cpu_addr,
  input logic             sie_in_tok,
  input logic             sie_in_ack,
  input logic             sie_out_tok,
  input logic             in_busy,
  input logic             in_stall,
  input logic             out_busy,
  input logic             out_stall,
  input logic [CNT_W-1:0] in_cnt,
  input logic [CNT_W-1:0] out_cnt,
  input logic             in_resp_vld,
  input logic [1:0]       in_resp_code,
  input logic             out_resp_vld,
  input logic [1:0]       out_resp_code,
  input logic             irq_in,
  input logic             irq_out
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_BYTES);

  assert_in_stall_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sie_in_tok && in_stall |=> in_resp_vld && in_resp_code == 2'd2);

  assert_out_stall_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sie_out_tok && out_stall |=> out_resp_vld && out_resp_code == 2'd2);

  assert_stall_keeps_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sie_out_tok && out_stall && !cpu_wr |=> out_busy == $past(out_busy));

  assert_unarmed_nak_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sie_in_tok && !in_stall && !in_busy |=> in_resp_code == 2'd1);

  assert_in_fall_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_busy) |-> irq_in);

  assert_out_fall_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_busy) |-> irq_out);

  assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_busy && cpu_wr && cpu_addr == 2'd1 |=> $stable(in_cnt));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= MAXC && out_cnt <= MAXC);

  assert_out_rx_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sie_out_tok && out_busy && !out_stall |=> !out_busy && out_resp_code == 2'd0);

  assert_ack_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sie_in_ack && !sie_in_tok && in_busy && !(in_resp_vld && in_resp_code == 2'd0)
      |=> in_busy || !$past(in_busy));
endmodule

bind ep_handshake_ctrl ep_hs_checker #(.CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .sie_in_tok(sie_in_tok), .sie_in_ack(sie_in_ack), .sie_out_tok(sie_out_tok),
  .in_busy(in_busy), .in_stall(in_stall), .out_busy(out_busy), .out_stall(out_stall),
  .in_cnt(in_cnt), .out_cnt(out_cnt),
  .in_resp_vld(in_resp_vld), .in_resp_code(in_resp_code),
  .out_resp_vld(out_resp_vld), .out_resp_code(out_resp_code),
  .irq_in(irq_in), .irq_out(irq_out)
);

// File: tb/ep_handshake_ctrl_tb.sv
module ep_handshake_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic sie_in_tok = 1'b0, sie_in_ack = 1'b0, sie_out_tok = 1'b0;
  logic [6:0] sie_out_cnt = 7'd0;
  logic in_resp_vld, out_resp_vld, irq_in, irq_out;
  logic [1:0] in_resp_code, out_resp_code;
  logic [6:0] in_tx_cnt;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_handshake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .sie_in_tok(sie_in_tok), .sie_in_ack(sie_in_ack),
    .sie_out_tok(sie_out_tok), .sie_out_cnt(sie_out_cnt),
    .in_resp_vld(in_resp_vld), .in_resp_code(in_resp_code), .in_tx_cnt(in_tx_cnt),
    .out_resp_vld(out_resp_vld), .out_resp_code(out_resp_code),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    step();
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    cpu_addr = a; #1;
    d = int'(cpu_rdata);
  endtask

  task automatic in_tok(output int vld, output int code);
    sie_in_tok = 1'b1; step(); sie_in_tok = 1'b0;
    vld = int'(in_resp_vld); code = int'(in_resp_code);
  endtask

  task automatic in_ack();
    sie_in_ack = 1'b1; step(); sie_in_ack = 1'b0;
  endtask

  task automatic out_tok(input logic [6:0] n, output int vld, output int code);
    sie_out_tok = 1'b1; sie_out_cnt = n; step(); sie_out_tok = 1'b0;
    vld = int'(out_resp_vld); code = int'(out_resp_code);
  endtask

  function automatic int clamp64(input int v);
    return (v > 64) ? 64 : v;
  endfunction

  initial begin
    int d, vld, code;
    step(); step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reg after reset", d, 0);
    end
    check("R1 irq_in reset", int'(irq_in), 0);
    check("R1 irq_out reset", int'(irq_out), 0);

    // R5 unarmed IN answers NAK
    in_tok(vld, code);
    check("R5 unarmed vld", vld, 1);
    check("R5 unarmed NAK", code, 1);

    // R2 busy bit not writable
    wr(2'd0, 8'h01);
    rd(2'd0, d);
    check("R2 busy write no effect", d, 0);

    // R6 stray ack ignored, then sweep the IN count over all 7-bit values
    for (int v = 0; v < 128; v++) begin
      wr(2'd1, 8'(v));
      rd(2'd0, d);
      check("R3 IN busy after arm", d & 1, 1);
      rd(2'd1, d);
      check("R3 IN count clamp", d, clamp64(v));
      wr(2'd1, 8'(v ^ 7'h15));
      rd(2'd1, d);
      check("R4 IN write while busy", d, clamp64(v));
      if (v % 16 == 0) begin
        in_ack();
        rd(2'd0, d);
        check("R6 stray ack keeps busy", d, 1);
      end
      in_tok(vld, code);
      check("R5 armed ACK", code, 0);
      check("R5 tx count", int'(in_tx_cnt), clamp64(v));
      in_ack();
      rd(2'd0, d);
      check("R6 ack releases, R9 irq set", d, 4);
      check("R9 irq_in high", int'(irq_in), 1);
      wr(2'd0, 8'h04);
      check("R9 irq_in cleared", int'(irq_in), 0);
    end

    // R8 OUT sweep
    out_tok(7'd5, vld, code);
    check("R8 unarmed OUT NAK", code, 1);
    for (int n = 0; n < 128; n++) begin
      wr(2'd3, 8'(255 - n));
      rd(2'd2, d);
      check("R8 OUT busy after arm", d, 1);
      out_tok(7'(n), vld, code);
      check("R8 OUT ACK", code, 0);
      rd(2'd3, d);
      check("R8 OUT rx count", d, clamp64(n));
      rd(2'd2, d);
      check("R8 OUT released, R9 irq", d, 4);
      wr(2'd2, 8'h04);
      check("R9 irq_out cleared", int'(irq_out), 0);
    end

    // R4 OUT count write while busy
    wr(2'd3, 8'd0);
    wr(2'd3, 8'd9);
    rd(2'd3, d);
    check("R4 OUT count unchanged", d, 64);

    // R7 stall on OUT while armed
    wr(2'd2, 8'h02);
    for (int k = 0; k < 3; k++) begin
      out_tok(7'd3, vld, code);
      check("R7 OUT STALL", code, 2);
    end
    rd(2'd2, d);
    check("R7 OUT busy kept, no irq", d, 3);
    wr(2'd2, 8'h00);
    out_tok(7'd3, vld, code);
    check("R7 OUT after unstall ACK", code, 0);
    wr(2'd2, 8'h04);

    // R7 stall on IN while armed, then release
    wr(2'd1, 8'd10);
    wr(2'd0, 8'h02);
    in_tok(vld, code);
    check("R7 IN STALL", code, 2);
    in_ack();
    rd(2'd0, d);
    check("R7 IN busy kept after stall", d, 3);
    check("R7 no irq_in", int'(irq_in), 0);
    wr(2'd0, 8'h00);
    in_tok(vld, code);
    check("R7 IN after unstall", code, 0);
    check("R5 tx count 10", int'(in_tx_cnt), 10);

    // R6 token without ack cancels the pending ack
    in_tok(vld, code);
    sie_in_tok = 1'b1; step(); sie_in_tok = 1'b0;
    step();
    rd(2'd0, d);
    check("R6 still busy pending", d, 1);

    // R9 set wins over same-cycle clear
    in_tok(vld, code);
    sie_in_ack = 1'b1; cpu_wr = 1'b1; cpu_addr = 2'd0; cpu_wdata = 8'h04;
    step();
    sie_in_ack = 1'b0; cpu_wr = 1'b0;
    check("R9 set beats clear", int'(irq_in), 1);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule